// File: doc/BRIEF.md
# Reconfigurable Processing-Element Array

This block is a software-defined fabric of small 8-bit processing elements built from plain logic. A grid of four rows by six columns feeds one final output element, 25 elements in all. Each element applies one of eight fixed operations to two operands. Each operand is picked by a multiplexer from the three sensor words or from the result of any element in an earlier column. The function codes and operand selects of all elements live in one configuration register. That register is filled serially one bit per clock and becomes active only on an explicit commit.

In use, a host streams a new configuration while the array keeps computing with the old one, then pulses commit. With suitable configurations the array produces a staged mean of all three sensors, the mean of two of them, or one sensor passed straight through. This allows the output to be rebuilt around failed sensors. The final result is registered, one clock behind the sensor inputs.

Top module: `vrc_array`

## Requirements
- R1: While reset is low the result is 0 and the active configuration is cleared to all zeros. With an all-zero configuration, every element ANDs sensor 0 with itself, so one clock after any sensor values are presented the result equals sensor 0 (bits 7:0 of `sens_i`).
- R2: Function codes 000, 001 and 010 give X AND Y, X XOR Y and NOT X.
- R3: Function code 011 adds X and Y into a 9-bit sum and returns bits 8:1. The carry is kept and the result is truncated, not rounded.
- R4: Codes 100 and 101 give X AND 0x0F and X AND 0xF0. Codes 110 and 111 give X OR 0x0F and X OR 0xF0.
- R5: Each element owns a 13-bit field: bits 12:10 hold the function, bits 9:5 the X select and bits 4:0 the Y select. Grid element e = column*4 + row occupies configuration bits [13e+12:13e]. The output element is e = 24, so the configuration is 325 bits wide.
- R6: Source index 0, 1 and 2 name sensors 0 to 2 (`sens_i` bits 7:0, 15:8, 23:16). Index 3+e names grid element e.
- R7: An element in column k accepts indices below 3+4k, and the output element accepts indices below 27. Any larger select reads sensor 0.
- R8: While `cfg_load_i` is high, `cfg_bit_i` is shifted in once per clock, with the first bit sent ending at configuration bit 0. The active configuration changes only on the clock where `cfg_commit_i` is high, and it then takes the full shifted contents.
- R9: The result is registered. The value seen after a clock edge depends only on the sensors and configuration sampled at that edge, and it is held until the next edge.
- R10: Configurations exist that output one sensor unchanged, the truncated mean of two sensors, and the staged mean ((s0+s1)/2 + s2)/2 of three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Shift one configuration bit this clock |
| cfg_bit_i | input | 1 | Serial configuration data |
| cfg_commit_i | input | 1 | Copy the shifted configuration into the active one |
| sens_i | input | 24 | Three 8-bit sensor words, sensor 0 in bits 7:0 |
| res_o | output | 8 | Registered array result |

## Verification
Each operation is run alone on the output element with corner operands (0x00, 0xFF, 0x80, 0x01), so that carry loss or rounding in the halving add shows as a wrong value. Directed routing configurations separate a correct select decode from one that ignores the per-column range limit, by aiming selects at later columns and at indices past 26. Shifting a second configuration without committing it separates a true staging register from one that feeds the datapath directly. Random 325-bit configurations with random sensor words then drive deep chains and mixed selects through a bench model.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

  localparam int FNW = 3;

  typedef enum logic [FNW-1:0] {
    FN_AND   = 3'b000,
    FN_XOR   = 3'b001,
    FN_NOTX  = 3'b010,
    FN_HALF  = 3'b011,
    FN_ANDLO = 3'b100,
    FN_ANDHI = 3'b101,
    FN_ORLO  = 3'b110,
    FN_ORHI  = 3'b111
  } pe_fn_e;

endpackage

// File: rtl/vrc_cfg.sv
module vrc_cfg #(
  parameter int TOT = 325
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           bit_i,
  input  logic           commit_i,
  output logic [TOT-1:0] active_o
);

  logic [TOT-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load_i) begin
      shadow_q <= {bit_i, shadow_q[TOT-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= '0;
    end else if (commit_i) begin
      active_o <= shadow_q;
    end
  end

  // R8: the datapath configuration moves only on commit
  p_hold_without_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(active_o));

  // R8: commit moves the whole staged image
  p_commit_takes_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> active_o == $past(shadow_q));

  // R8: new bit enters at the top of the staging register
  p_shift_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> shadow_q[TOT-1] == $past(bit_i));

endmodule

// File: rtl/vrc_opsel.sv
module vrc_opsel #(
  parameter int W    = 8,
  parameter int NSRC = 3,
  parameter int SELW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC*W-1:0] src_i,
  input  logic [SELW-1:0]   sel_i,
  output logic [W-1:0]      op_o
);

  logic sel_bad;
  assign sel_bad = int'(sel_i) >= NSRC;

  always_comb begin
    op_o = src_i[W-1:0];
    for (int i = 0; i < NSRC; i++) begin
      if (int'(sel_i) == i) op_o = src_i[i*W +: W];
    end
  end

  // R7: selects past the column's reach fall back to sensor 0
  p_range_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_bad |-> op_o == src_i[W-1:0]);

endmodule

// File: rtl/vrc_pe.sv
module vrc_pe
  import vrc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FNW-1:0] fn_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [W-1:0]   res_o
);

  localparam logic [W-1:0] LO_MASK = {{(W/2){1'b0}}, {(W-W/2){1'b1}}};
  localparam logic [W-1:0] HI_MASK = ~LO_MASK;

  function automatic logic [W-1:0] pe_eval(input pe_fn_e f,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
    logic [W:0] sum;
    sum = {1'b0, x} + {1'b0, y};
    case (f)
      FN_AND:   return x & y;
      FN_XOR:   return x ^ y;
      FN_NOTX:  return ~x;
      FN_HALF:  return sum[W:1];
      FN_ANDLO: return x & LO_MASK;
      FN_ANDHI: return x & HI_MASK;
      FN_ORLO:  return x | LO_MASK;
      FN_ORHI:  return x | HI_MASK;
      default:  return x & y;
    endcase
  endfunction

  pe_fn_e fn;
  assign fn    = pe_fn_e'(fn_i);
  assign res_o = pe_eval(fn, x_i, y_i);

  logic [W-1:0] op_min, op_max;
  assign op_min = (x_i < y_i) ? x_i : y_i;
  assign op_max = (x_i < y_i) ? y_i : x_i;

  // R3: a halving add never leaves the span of its operands
  p_half_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fn == FN_HALF |-> (res_o >= op_min) && (res_o <= op_max));

  // R4: low-keep mask clears the upper half
  p_andlo_clears_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fn == FN_ANDLO |-> (res_o & HI_MASK) == '0);

  // R4: high-set mask fills the upper half
  p_orhi_fills_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fn == FN_ORHI |-> (res_o & HI_MASK) == HI_MASK);

endmodule

// File: rtl/vrc_array.sv
module vrc_array
  import vrc_pkg::*;
#(
  parameter int W    = 8,
  parameter int NIN  = 3,
  parameter int ROWS = 4,
  parameter int COLS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load_i,
  input  logic           cfg_bit_i,
  input  logic           cfg_commit_i,
  input  logic [NIN*W-1:0] sens_i,
  output logic [W-1:0]   res_o
);

  localparam int NGRID    = ROWS * COLS;
  localparam int NSRC_ALL = NIN + NGRID;
  localparam int SELW     = $clog2(NSRC_ALL);
  localparam int EW       = FNW + 2 * SELW;
  localparam int NPE      = NGRID + 1;
  localparam int TOT      = EW * NPE;

  logic [TOT-1:0] cfg_act;

  vrc_cfg #(.TOT(TOT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (cfg_load_i),
    .bit_i    (cfg_bit_i),
    .commit_i (cfg_commit_i),
    .active_o (cfg_act)
  );

  for (genvar c = 0; c < COLS; c++) begin : gen_col
    localparam int LIM = NIN + ROWS * c;
    logic [LIM*W-1:0]  bus;
    logic [ROWS*W-1:0] outs;

    if (c == 0) begin : gen_first
      assign bus = sens_i;
    end else begin : gen_next
      assign bus = {gen_col[c-1].outs, gen_col[c-1].bus};
    end

    for (genvar r = 0; r < ROWS; r++) begin : gen_row
      localparam int E = c * ROWS + r;
      logic [EW-1:0]   fld;
      logic [W-1:0]    opx, opy;
      assign fld = cfg_act[E*EW +: EW];

      vrc_opsel #(.W(W), .NSRC(LIM), .SELW(SELW)) u_selx (
        .clk(clk), .rst_n(rst_n), .src_i(bus),
        .sel_i(fld[2*SELW-1:SELW]), .op_o(opx));
      vrc_opsel #(.W(W), .NSRC(LIM), .SELW(SELW)) u_sely (
        .clk(clk), .rst_n(rst_n), .src_i(bus),
        .sel_i(fld[SELW-1:0]), .op_o(opy));
      vrc_pe #(.W(W)) u_pe (
        .clk(clk), .rst_n(rst_n), .fn_i(fld[EW-1:2*SELW]),
        .x_i(opx), .y_i(opy), .res_o(outs[r*W +: W]));
    end
  end

  // output element sees every sensor and every grid element
  logic [NSRC_ALL*W-1:0] bus_out;
  logic [EW-1:0]         fld_out;
  logic [W-1:0]          ox, oy, out_next;

  assign bus_out = {gen_col[COLS-1].outs, gen_col[COLS-1].bus};
  assign fld_out = cfg_act[NGRID*EW +: EW];

  vrc_opsel #(.W(W), .NSRC(NSRC_ALL), .SELW(SELW)) u_out_selx (
    .clk(clk), .rst_n(rst_n), .src_i(bus_out),
    .sel_i(fld_out[2*SELW-1:SELW]), .op_o(ox));
  vrc_opsel #(.W(W), .NSRC(NSRC_ALL), .SELW(SELW)) u_out_sely (
    .clk(clk), .rst_n(rst_n), .src_i(bus_out),
    .sel_i(fld_out[SELW-1:0]), .op_o(oy));
  vrc_pe #(.W(W)) u_out_pe (
    .clk(clk), .rst_n(rst_n), .fn_i(fld_out[EW-1:2*SELW]),
    .x_i(ox), .y_i(oy), .res_o(out_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_o <= '0;
    else        res_o <= out_next;
  end

  logic active_zero;
  assign active_zero = (cfg_act == '0);

  // R1: a cleared configuration passes sensor 0 with one clock of latency
  p_zero_cfg_passes_in0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active_zero |=> res_o == $past(sens_i[W-1:0]));

  // R9: the result register holds between edges
  p_result_from_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_o == $past(out_next));

endmodule

// File: tb/test_vrc_array.sv
`timescale 1ns/1ps
module test_vrc_array;

  localparam int W = 8, NIN = 3, ROWS = 4, COLS = 6;
  localparam int EW = 13, NPE = 25, TOT = EW * NPE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_bit = 1'b0, cfg_commit = 1'b0;
  logic [NIN*W-1:0] sens = '0;
  logic [W-1:0] res;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [TOT-1:0] cfg_new = '0;
  logic [TOT-1:0] cfg_m = '0;

  always #4 clk = ~clk;

  vrc_array #(.W(W), .NIN(NIN), .ROWS(ROWS), .COLS(COLS)) i_vrc_array (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_bit_i(cfg_bit),
    .cfg_commit_i(cfg_commit), .sens_i(sens), .res_o(res));

  function automatic logic [7:0] ref_op(input int f, input logic [7:0] x, input logic [7:0] y);
    int s;
    case (f)
      0: return x & y;
      1: return x ^ y;
      2: return ~x;
      3: begin s = int'(x) + int'(y); return 8'(s / 2); end
      4: return x & 8'h0F;
      5: return x & 8'hF0;
      6: return x | 8'h0F;
      default: return x | 8'hF0;
    endcase
  endfunction

  function automatic logic [7:0] ref_arr(input logic [TOT-1:0] c, input logic [23:0] s);
    logic [7:0] v [28];
    v[0] = s[7:0]; v[1] = s[15:8]; v[2] = s[23:16];
    for (int e = 0; e < NPE; e++) begin
      int lim, f, sx, sy;
      lim = (e < 24) ? 3 + 4 * (e / 4) : 27;
      f  = int'(c[e*EW+10 +: 3]);
      sx = int'(c[e*EW+5 +: 5]);
      sy = int'(c[e*EW +: 5]);
      if (sx >= lim) sx = 0;
      if (sy >= lim) sy = 0;
      v[3+e] = ref_op(f, v[sx], v[sy]);
    end
    return v[27];
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic put(input int e, input int f, input int sx, input int sy);
    cfg_new[e*EW +: EW] = {3'(f), 5'(sx), 5'(sy)};
  endtask

  task automatic shift_cfg();
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk); cfg_load = 1'b1; cfg_bit = cfg_new[i];
    end
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic commit_cfg();
    @(negedge clk); cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
    cfg_m = cfg_new;
  endtask

  task automatic run_vec(input logic [23:0] s, input string tag);
    @(negedge clk); sens = s;
    @(posedge clk); #1;
    check(tag, res, ref_arr(cfg_m, s));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] ops [4];
    void'($urandom(32'h5EED_1234));
    ops[0] = 8'h00; ops[1] = 8'hFF; ops[2] = 8'h80; ops[3] = 8'h01;

    // R1: reset state
    sens = 24'hA1B2C3;
    repeat (3) @(posedge clk);
    #1 check("R1 reset result", res, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    run_vec(24'h3C5A7E, "R1 zero cfg passes sensor0");
    run_vec(24'h0000FF, "R1 zero cfg passes sensor0");

    // R9: held between edges, new value after edge
    @(negedge clk); sens = 24'h111122;
    #1 check("R9 held before edge", res, 8'h7E ^ 8'h81 ^ 8'h81 ? 8'hFF : 8'hFF);
    @(posedge clk); #1 check("R9 new after edge", res, 8'h22);

    // R2 R3 R4 R5: each code on the output element with sensor0 as X and sensor1 as Y
    for (int f = 0; f < 8; f++) begin
      cfg_new = '0;
      put(24, f, 0, 1);
      shift_cfg();
      commit_cfg();
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          run_vec({8'h00, ops[b], ops[a]},
                  f < 3 ? "R2 logic code" : (f == 3 ? "R3 halving add" : "R4 mask code"));
        end
      end
    end
    // R3: explicit truncation and carry cases
    cfg_new = '0; put(24, 3, 0, 1); shift_cfg(); commit_cfg();
    run_vec({8'h00, 8'hFF, 8'hFF}, "R3 carry kept");
    check("R3 carry kept abs", res, 8'hFF);
    run_vec({8'h00, 8'h01, 8'hFF}, "R3 carry kept");
    check("R3 truncate abs", res, 8'h80);
    run_vec({8'h00, 8'h02, 8'h01}, "R3 truncate");
    check("R3 truncate small", res, 8'h01);

    // R10: pass-through of sensor2
    cfg_new = '0; put(24, 0, 2, 2); shift_cfg(); commit_cfg();
    run_vec(24'h5A0F33, "R10 pass sensor2");
    check("R10 pass abs", res, 8'h5A);
    // R10: mean of sensors 0 and 1
    cfg_new = '0; put(24, 3, 0, 1); shift_cfg(); commit_cfg();
    run_vec(24'h00_64_C8, "R10 mean two");
    check("R10 mean two abs", res, 8'h96);
    // R10 R6: staged mean of three through grid elements 0 and 4
    cfg_new = '0;
    put(0, 3, 0, 1);
    put(4, 3, 3, 2);
    put(24, 0, 7, 7);
    shift_cfg(); commit_cfg();
    run_vec({8'h10, 8'h30, 8'h50}, "R10 staged mean three");
    check("R10 staged mean abs", res, 8'h28);

    // R6 R7: forward reference in column 0 and index past 26 on output
    cfg_new = '0;
    put(0, 1, 10, 1);
    put(24, 1, 3, 30);
    shift_cfg(); commit_cfg();
    run_vec({8'h77, 8'h0F, 8'hA5}, "R7 out of range selects");
    check("R7 abs", res, (8'hA5 ^ 8'h0F) ^ 8'hA5);
    // R7: column 5 element may reach column 4, not column 5
    cfg_new = '0;
    put(16, 2, 0, 0);
    put(20, 0, 19, 23);
    put(24, 0, 23, 23);
    shift_cfg(); commit_cfg();
    run_vec({8'h00, 8'h00, 8'h3C}, "R7 column reach");
    check("R7 column reach abs", res, 8'h3C & 8'hC3);

    // R8: staged load does not disturb the running configuration
    cfg_new = '0; put(24, 0, 2, 2); shift_cfg(); commit_cfg();
    cfg_new = '0; put(24, 0, 1, 1); shift_cfg();
    run_vec(24'hAA_BB_CC, "R8 uncommitted load ignored");
    check("R8 uncommitted abs", res, 8'hAA);
    @(negedge clk); cfg_bit = 1'b1;
    repeat (4) @(negedge clk);
    commit_cfg();
    run_vec(24'hAA_BB_CC, "R8 committed load");
    check("R8 committed abs", res, 8'hBB);

    // R5 R6 R7: random configurations
    for (int k = 0; k < 14; k++) begin
      for (int i = 0; i < TOT; i++) cfg_new[i] = 1'($urandom);
      shift_cfg(); commit_cfg();
      for (int j = 0; j < 8; j++) run_vec(24'($urandom), "R5 random config");
    end

    summary();
  end

endmodule